// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Engine

This block is the arithmetic core of a signal-processing unit. Each cycle in which `op_valid` is high, it takes two 16-bit operands and an operation code. It forms a product or a squared difference in a 17x17 signed multiplier and combines the result with one of two 40-bit accumulators in a 41-bit adder/subtracter. The sum is then optionally clamped and written back into the selected accumulator. Each accumulator holds eight guard bits above a 32-bit (1.31) working range.

Several configuration inputs shape the arithmetic:
- Operands are treated as signed or unsigned.
- The product is either an integer or a fraction doubled to align the binary point.
- Saturation on accumulator writes is enabled separately for each accumulator, and one mode bit chooses between clamping to the 32-bit working range and clamping to the full 40-bit width.

A combinational store path reads either accumulator and rounds it to a 16-bit word. Rounding is conventional or round-half-to-even. The word can optionally be clamped to the 16-bit range.

Top module: `dsp_mac_engine`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both accumulators become zero, and the store word reads 0x0000.
- R2: An accumulator changes only at a clock edge where `op_valid` is high, the code writes an accumulator, and `acc_sel` selects it (0 = accumulator A, 1 = accumulator B). The unselected accumulator is left unchanged. Code 10 (move, no write) leaves both accumulators unchanged.
- R3: Operation codes are 0 no-op, 2 load product, 4 load negated product, 5 add product, 7 subtract product. In each case the product is x*y, with both operands sign-extended to 17 bits when `cfg_signed` is 1 and zero-extended when it is 0.
- R4: Code 3 loads x*x and code 6 adds x*x; y is ignored. Code 8 loads (x-y)² and code 9 adds (x-y)². The difference is formed from the 17-bit extended operands.
- R5: When `cfg_frac` is 1, the product is doubled before it is sign-extended to 40 bits.
- R6: Code 1 clears the selected accumulator. Code 11 adds the other accumulator into the selected one, code 12 subtracts the other accumulator from it, and code 13 negates it. None of these use the operands.
- R7: With saturation disabled for the selected accumulator, the result wraps modulo 2^40.
- R8: With saturation enabled and `cfg_super_sat` at 0, a result outside the signed 32-bit range becomes 0x007FFFFFFF or 0xFF80000000.
- R9: With saturation enabled and `cfg_super_sat` at 1, a result outside the signed 40-bit range becomes 0x7FFFFFFFFF or 0x8000000000.
- R10: `store_word` is bits 31:16 of the accumulator selected by `store_sel`, after 0x8000 is added to the 41-bit sign-extended value.
- R11: With `cfg_convergent` at 1 and bits 15:0 exactly 0x8000, the 0x8000 is added only when bit 16 is 1, so the word rounds to even.
- R12: With `cfg_sat_store` at 1, a rounded value outside the signed 32-bit range gives 0x7FFF if it is positive and 0x8000 if it is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Execute `op_code` this cycle |
| op_code | input | 4 | Operation code (see R3, R4, R6) |
| acc_sel | input | 1 | Target accumulator: 0 = A, 1 = B |
| opnd_x | input | 16 | First operand |
| opnd_y | input | 16 | Second operand |
| cfg_frac | input | 1 | 1 = fractional product (doubled) |
| cfg_signed | input | 1 | 1 = signed operands |
| cfg_convergent | input | 1 | 1 = round half to even on store |
| cfg_sat_a | input | 1 | Saturation enable for accumulator A |
| cfg_sat_b | input | 1 | Saturation enable for accumulator B |
| cfg_sat_store | input | 1 | Clamp the store word to 16 bits |
| cfg_super_sat | input | 1 | 1 = clamp to 40 bits, 0 = clamp to 32 bits |
| store_sel | input | 1 | Accumulator read by the store path |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| store_word | output | 16 | Rounded, optionally clamped 16-bit word |

## Verification
The properties assume that the configuration bits seen at an accepted operation are the ones that govern its result. They also assume that `op_code` carries one of the defined codes whenever `op_valid` is high. The bench holds every input steady from one falling edge to the next and pulses `op_valid` for exactly one cycle per operation. It drives only codes 0 to 13. To reach the 40-bit overflow boundary, the bench accumulates a large product repeatedly rather than relying on a single multiply, which can never reach it.

// File: rtl/dsp_mac_pkg.sv
// Package: shared operation codes and the decode table for the MAC engine.
// Assumes: op codes above 13 behave as a no-op.
package dsp_mac_pkg;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_CLR    = 4'd1,
        OP_MPY    = 4'd2,
        OP_MPYSQ  = 4'd3,
        OP_MPYN   = 4'd4,
        OP_MAC    = 4'd5,
        OP_MACSQ  = 4'd6,
        OP_MSC    = 4'd7,
        OP_ED     = 4'd8,
        OP_EDAC   = 4'd9,
        OP_MOVE   = 4'd10,
        OP_ADDACC = 4'd11,
        OP_SUBACC = 4'd12,
        OP_NEGACC = 4'd13
    } dsp_op_e;

    typedef enum logic [1:0] {
        ADD_NONE,
        ADD_PROD,
        ADD_OTHER,
        ADD_SELF
    } addend_e;

    typedef struct packed {
        logic    write;
        logic    base_dest;
        logic    subtract;
        addend_e addend;
        logic    square;
        logic    diff;
    } dsp_dec_t;

    // Map an operation code to datapath controls.
    function automatic dsp_dec_t dsp_decode(input dsp_op_e op);
        dsp_dec_t d;
        d = '{write: 1'b0, base_dest: 1'b0, subtract: 1'b0,
              addend: ADD_NONE, square: 1'b0, diff: 1'b0};
        case (op)
            OP_CLR:    d.write = 1'b1;
            OP_MPY:    begin d.write = 1'b1; d.addend = ADD_PROD; end
            OP_MPYSQ:  begin d.write = 1'b1; d.addend = ADD_PROD; d.square = 1'b1; end
            OP_MPYN:   begin d.write = 1'b1; d.addend = ADD_PROD; d.subtract = 1'b1; end
            OP_MAC:    begin d.write = 1'b1; d.addend = ADD_PROD; d.base_dest = 1'b1; end
            OP_MACSQ:  begin d.write = 1'b1; d.addend = ADD_PROD; d.base_dest = 1'b1;
                             d.square = 1'b1; end
            OP_MSC:    begin d.write = 1'b1; d.addend = ADD_PROD; d.base_dest = 1'b1;
                             d.subtract = 1'b1; end
            OP_ED:     begin d.write = 1'b1; d.addend = ADD_PROD; d.diff = 1'b1; end
            OP_EDAC:   begin d.write = 1'b1; d.addend = ADD_PROD; d.base_dest = 1'b1;
                             d.diff = 1'b1; end
            OP_ADDACC: begin d.write = 1'b1; d.addend = ADD_OTHER; d.base_dest = 1'b1; end
            OP_SUBACC: begin d.write = 1'b1; d.addend = ADD_OTHER; d.base_dest = 1'b1;
                             d.subtract = 1'b1; end
            OP_NEGACC: begin d.write = 1'b1; d.addend = ADD_SELF; d.subtract = 1'b1; end
            default:   d.write = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dsp_mac_mult.sv
// Module: operand extension, optional difference, 17x17 signed multiply and
// fractional scaling, sign-extended to accumulator width.
// Assumes: ACC_W is at least 2*(DATA_W+1)+1 so the doubled product fits.
module dsp_mac_mult #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              sgn,
    input  logic              frac,
    input  logic              square,
    input  logic              diff,
    output logic [ACC_W-1:0]  prod_ext
);
    localparam int OPW = DATA_W + 1;
    localparam int PW  = 2 * OPW;

    logic signed [OPW-1:0] xe, ye, dxy, ma, mb;
    logic signed [PW-1:0]  prod;
    logic        [ACC_W-1:0] wide;

    // Extend operands, pick multiplier inputs and form the scaled product.
    always_comb begin
        xe   = {sgn & x[DATA_W-1], x};
        ye   = {sgn & y[DATA_W-1], y};
        dxy  = xe - ye;
        ma   = diff ? dxy : xe;
        mb   = (diff || square) ? ma : ye;
        prod = ma * mb;
        wide = {{(ACC_W-PW){prod[PW-1]}}, prod};
        prod_ext = frac ? (wide << 1) : wide;
    end
endmodule

// File: rtl/dsp_mac_addsat.sv
// Module: 41-bit add/subtract with selectable 32-bit or full-width clamp.
// Assumes: operands are two's complement ACC_W-bit values.
module dsp_mac_addsat #(
    parameter int ACC_W  = 40,
    parameter int NORM_W = 32
) (
    input  logic [ACC_W-1:0] base,
    input  logic [ACC_W-1:0] addend,
    input  logic             subtract,
    input  logic             sat_en,
    input  logic             super_mode,
    output logic [ACC_W-1:0] result
);
    localparam int HI_N = ACC_W - NORM_W + 2;
    localparam logic [ACC_W-1:0] MAX_FULL = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MIN_FULL = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] MAX_NORM = {{(ACC_W-NORM_W+1){1'b0}}, {(NORM_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MIN_NORM = {{(ACC_W-NORM_W+1){1'b1}}, {(NORM_W-1){1'b0}}};

    logic [ACC_W:0]   sum;
    logic [HI_N-1:0]  hi;
    logic             ovf_full, ovf_norm, neg;

    // Exact sum, overflow detection and clamp selection.
    always_comb begin
        sum = subtract ? ({base[ACC_W-1], base} - {addend[ACC_W-1], addend})
                       : ({base[ACC_W-1], base} + {addend[ACC_W-1], addend});
        hi       = sum[ACC_W:NORM_W-1];
        neg      = sum[ACC_W];
        ovf_full = sum[ACC_W] ^ sum[ACC_W-1];
        ovf_norm = !((&hi) || !(|hi));
        if (!sat_en)
            result = sum[ACC_W-1:0];
        else if (super_mode)
            result = ovf_full ? (neg ? MIN_FULL : MAX_FULL) : sum[ACC_W-1:0];
        else
            result = ovf_norm ? (neg ? MIN_NORM : MAX_NORM) : sum[ACC_W-1:0];
    end
endmodule

// File: rtl/dsp_mac_store.sv
// Module: rounds an accumulator to a DATA_W-bit word, conventional or
// round-half-to-even, with optional clamp to the word range.
// Assumes: the word sits at bits NORM_W-1 down to NORM_W-DATA_W.
module dsp_mac_store #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40,
    parameter int NORM_W = 32
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic              convergent,
    input  logic              sat_en,
    output logic [DATA_W-1:0] word
);
    localparam int LSB_W = NORM_W - DATA_W;
    localparam int HI_N  = ACC_W - NORM_W + 2;
    localparam logic [LSB_W-1:0]  TIE   = {1'b1, {(LSB_W-1){1'b0}}};
    localparam logic [ACC_W:0]    HALF  = {{(ACC_W-LSB_W+1){1'b0}}, TIE};
    localparam logic [DATA_W-1:0] W_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] W_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    logic            add_half;
    logic [ACC_W:0]  rnd;
    logic [HI_N-1:0] hi;
    logic            ovf;

    // Decide on the rounding increment, apply it and clamp the word.
    always_comb begin
        add_half = !(convergent && (acc[LSB_W-1:0] == TIE) && !acc[LSB_W]);
        rnd      = {acc[ACC_W-1], acc} + (add_half ? HALF : '0);
        hi       = rnd[ACC_W:NORM_W-1];
        ovf      = !((&hi) || !(|hi));
        word     = (sat_en && ovf) ? (rnd[ACC_W] ? W_MIN : W_MAX)
                                   : rnd[NORM_W-1:LSB_W];
    end
endmodule

// File: rtl/dsp_mac_engine.sv
// Module: top of the dual-accumulator MAC engine. Decodes the operation,
// multiplies, adds into the selected accumulator with optional clamp, and
// exposes a rounded store word for either accumulator.
// Assumes: configuration inputs are valid in the cycle op_valid is high.
module dsp_mac_engine
    import dsp_mac_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40,
    parameter int NORM_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic              acc_sel,
    input  logic [DATA_W-1:0] opnd_x,
    input  logic [DATA_W-1:0] opnd_y,
    input  logic              cfg_frac,
    input  logic              cfg_signed,
    input  logic              cfg_convergent,
    input  logic              cfg_sat_a,
    input  logic              cfg_sat_b,
    input  logic              cfg_sat_store,
    input  logic              cfg_super_sat,
    input  logic              store_sel,
    output logic [ACC_W-1:0]  acc_a,
    output logic [ACC_W-1:0]  acc_b,
    output logic [DATA_W-1:0] store_word
);
    localparam int NUM_ACC = 2;

    dsp_dec_t         dec;
    logic [ACC_W-1:0] acc_q [NUM_ACC];
    logic [ACC_W-1:0] dest, other, base, addend, prod_ext, result;
    logic             sat_en;

    // Decode the operation and select accumulator operands.
    always_comb begin
        dec    = dsp_decode(dsp_op_e'(op_code));
        dest   = acc_q[acc_sel];
        other  = acc_q[!acc_sel];
        sat_en = acc_sel ? cfg_sat_b : cfg_sat_a;
        base   = dec.base_dest ? dest : '0;
        case (dec.addend)
            ADD_PROD:  addend = prod_ext;
            ADD_OTHER: addend = other;
            ADD_SELF:  addend = dest;
            default:   addend = '0;
        endcase
    end

    dsp_mac_mult #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mult (
        .x        (opnd_x),
        .y        (opnd_y),
        .sgn      (cfg_signed),
        .frac     (cfg_frac),
        .square   (dec.square),
        .diff     (dec.diff),
        .prod_ext (prod_ext)
    );

    dsp_mac_addsat #(.ACC_W(ACC_W), .NORM_W(NORM_W)) u_addsat (
        .base       (base),
        .addend     (addend),
        .subtract   (dec.subtract),
        .sat_en     (sat_en),
        .super_mode (cfg_super_sat),
        .result     (result)
    );

    for (genvar gi = 0; gi < NUM_ACC; gi++) begin : g_acc
        // Accumulator register: cleared in reset, loaded when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc_q[gi] <= '0;
            else if (op_valid && dec.write && (acc_sel == gi[0]))
                acc_q[gi] <= result;
        end
    end

    dsp_mac_store #(.DATA_W(DATA_W), .ACC_W(ACC_W), .NORM_W(NORM_W)) u_store (
        .acc        (acc_q[store_sel]),
        .convergent (cfg_convergent),
        .sat_en     (cfg_sat_store),
        .word       (store_word)
    );

    // Drive the accumulator outputs.
    always_comb begin
        acc_a = acc_q[0];
        acc_b = acc_q[1];
    end
endmodule

// File: rtl/dsp_mac_engine_chk.sv
// Checker: temporal properties of the MAC engine, bound to its top.
// Assumes: op codes 10 and 0 never write; code 1 clears.
module dsp_mac_engine_chk #(
    parameter int ACC_W  = 40,
    parameter int NORM_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [3:0]       op_code,
    input logic             acc_sel,
    input logic             cfg_sat_a,
    input logic             cfg_sat_b,
    input logic             cfg_super_sat,
    input logic [ACC_W-1:0] acc_a,
    input logic [ACC_W-1:0] acc_b
);
    localparam int HI_N = ACC_W - NORM_W + 1;

    logic writes;
    // Whether the current code writes an accumulator, from the code values.
    always_comb writes = (op_code != 4'd0) && (op_code != 4'd10) && (op_code <= 4'd13);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (acc_a == '0 && acc_b == '0));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc_a) && $stable(acc_b)));

    a_r2_b_sel_keeps_a: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && acc_sel) |=> $stable(acc_a));

    a_r2_a_sel_keeps_b: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !acc_sel) |=> $stable(acc_b));

    a_r2_move_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd10) |=> ($stable(acc_a) && $stable(acc_b)));

    a_r6_clear_a: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd1 && !acc_sel) |=> (acc_a == '0));

    a_r8_norm_range_a: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && writes && !acc_sel && cfg_sat_a && !cfg_super_sat)
        |=> ($countones(acc_a[ACC_W-1:NORM_W-1]) == 0 ||
             $countones(acc_a[ACC_W-1:NORM_W-1]) == HI_N));

    a_r8_norm_range_b: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && writes && acc_sel && cfg_sat_b && !cfg_super_sat)
        |=> ($countones(acc_b[ACC_W-1:NORM_W-1]) == 0 ||
             $countones(acc_b[ACC_W-1:NORM_W-1]) == HI_N));
endmodule

bind dsp_mac_engine dsp_mac_engine_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_code       (op_code),
    .acc_sel       (acc_sel),
    .cfg_sat_a     (cfg_sat_a),
    .cfg_sat_b     (cfg_sat_b),
    .cfg_super_sat (cfg_super_sat),
    .acc_a         (acc_a),
    .acc_b         (acc_b)
);

// File: tb/dsp_mac_engine_test.sv
// Bench: vector table walked by one loop, then directed reset, overflow
// and saturation tests. Configuration vector order:
// {frac, signed, convergent, sat_a, sat_b, sat_store, super_sat}.
module dsp_mac_engine_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  op_code;
    logic        acc_sel;
    logic [15:0] opnd_x, opnd_y;
    logic        cfg_frac, cfg_signed, cfg_convergent;
    logic        cfg_sat_a, cfg_sat_b, cfg_sat_store, cfg_super_sat;
    logic        store_sel;
    logic [39:0] acc_a, acc_b;
    logic [15:0] store_word;

    int checks   = 0;
    int failures = 0;
    logic [39:0] exp_a, exp_b;

    always #5 clk = ~clk;

    dsp_mac_engine uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_sel(acc_sel), .opnd_x(opnd_x), .opnd_y(opnd_y),
        .cfg_frac(cfg_frac), .cfg_signed(cfg_signed),
        .cfg_convergent(cfg_convergent), .cfg_sat_a(cfg_sat_a),
        .cfg_sat_b(cfg_sat_b), .cfg_sat_store(cfg_sat_store),
        .cfg_super_sat(cfg_super_sat), .store_sel(store_sel),
        .acc_a(acc_a), .acc_b(acc_b), .store_word(store_word)
    );

    // Row: {req(4), op(4), sel(1), x(16), y(16), cfg(7), exp_acc(40), exp_word(16)}
    localparam int NV = 21;
    localparam logic [103:0] VEC [NV] = '{
        {4'd3,  4'd2,  1'b0, 16'h0003, 16'h0004, 7'b0100000, 40'h000000000C, 16'h0000}, // R3 load
        {4'd3,  4'd5,  1'b0, 16'hFFFE, 16'h0005, 7'b0100000, 40'h0000000002, 16'h0000}, // R3 add
        {4'd3,  4'd7,  1'b0, 16'h0003, 16'h0003, 7'b0100000, 40'hFFFFFFFFF9, 16'h0000}, // R3 sub
        {4'd3,  4'd4,  1'b1, 16'h0004, 16'h0005, 7'b0100000, 40'hFFFFFFFFEC, 16'h0000}, // R3 neg
        {4'd10, 4'd2,  1'b1, 16'hFFFF, 16'hFFFF, 7'b0000000, 40'h00FFFE0001, 16'hFFFE}, // R10 unsigned
        {4'd12, 4'd10, 1'b1, 16'h0000, 16'h0000, 7'b0000010, 40'h00FFFE0001, 16'h7FFF}, // R12 clamp
        {4'd3,  4'd2,  1'b0, 16'hFFFF, 16'hFFFF, 7'b0100000, 40'h0000000001, 16'h0000}, // R3 signed
        {4'd4,  4'd3,  1'b0, 16'hFFFD, 16'h1234, 7'b0100000, 40'h0000000009, 16'h0000}, // R4 square
        {4'd4,  4'd6,  1'b0, 16'h0004, 16'h5555, 7'b0100000, 40'h0000000019, 16'h0000}, // R4 add sq
        {4'd4,  4'd8,  1'b0, 16'h000A, 16'h0003, 7'b0100000, 40'h0000000031, 16'h0000}, // R4 ed
        {4'd4,  4'd9,  1'b0, 16'h0002, 16'h0007, 7'b0100000, 40'h000000004A, 16'h0000}, // R4 edac
        {4'd5,  4'd2,  1'b0, 16'h4000, 16'h4000, 7'b1100000, 40'h0020000000, 16'h2000}, // R5 frac
        {4'd5,  4'd2,  1'b0, 16'h8000, 16'h8000, 7'b1100000, 40'h0080000000, 16'h8000}, // R5 -1*-1
        {4'd8,  4'd2,  1'b0, 16'h8000, 16'h8000, 7'b1101000, 40'h007FFFFFFF, 16'h8000}, // R8 clamp
        {4'd12, 4'd10, 1'b0, 16'h0000, 16'h0000, 7'b1101010, 40'h007FFFFFFF, 16'h7FFF}, // R12 clamp
        {4'd11, 4'd2,  1'b0, 16'h0080, 16'h0100, 7'b0110000, 40'h0000008000, 16'h0000}, // R11 tie even
        {4'd10, 4'd10, 1'b0, 16'h0000, 16'h0000, 7'b0100000, 40'h0000008000, 16'h0001}, // R10 tie up
        {4'd11, 4'd2,  1'b0, 16'h0180, 16'h0100, 7'b0110000, 40'h0000018000, 16'h0002}, // R11 tie odd
        {4'd11, 4'd2,  1'b0, 16'h8001, 16'h0001, 7'b0010000, 40'h0000008001, 16'h0001}, // R11 non-tie
        {4'd4,  4'd8,  1'b0, 16'h0000, 16'hFFFF, 7'b0000000, 40'h00FFFE0001, 16'hFFFE}, // R4 unsigned ed
        {4'd4,  4'd8,  1'b0, 16'h0000, 16'hFFFF, 7'b0100000, 40'h0000000001, 16'h0000}  // R4 signed ed
    };

    // Compare one value and log a failure.
    task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one operation from a falling edge; return at the next falling edge.
    task automatic run_op(input logic [3:0] op, input logic sel,
                          input logic [15:0] x, input logic [15:0] y,
                          input logic [6:0] cfg, input logic ssel);
        op_code = op; acc_sel = sel; opnd_x = x; opnd_y = y; store_sel = ssel;
        {cfg_frac, cfg_signed, cfg_convergent, cfg_sat_a, cfg_sat_b,
         cfg_sat_store, cfg_super_sat} = cfg;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_code = 4'd0; acc_sel = 1'b0;
        opnd_x = '0; opnd_y = '0; store_sel = 1'b0;
        {cfg_frac, cfg_signed, cfg_convergent, cfg_sat_a, cfg_sat_b,
         cfg_sat_store, cfg_super_sat} = 7'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset acc_a", acc_a, 40'h0);
        chk("R1 reset acc_b", acc_b, 40'h0);
        chk("R1 reset word", {24'h0, store_word}, 40'h0);
        rst_n = 1'b1;
        @(negedge clk);
        exp_a = '0; exp_b = '0;

        // Table walk: selected accumulator, unselected one (R2), store word.
        for (int i = 0; i < NV; i++) begin
            logic [103:0] v;
            v = VEC[i];
            run_op(v[99:96], v[95], v[94:79], v[78:63], v[62:56], v[95]);
            if (v[95]) exp_b = v[55:16]; else exp_a = v[55:16];
            chk($sformatf("R%0d row %0d acc_a", v[103:100], i), acc_a, exp_a);
            chk($sformatf("R%0d row %0d acc_b", v[103:100], i), acc_b, exp_b);
            chk($sformatf("R%0d row %0d word", v[103:100], i),
                {24'h0, store_word}, {24'h0, v[15:0]});
        end

        // R2: a multiply code with op_valid low changes nothing.
        op_code = 4'd2; opnd_x = 16'h0005; opnd_y = 16'h0005; op_valid = 1'b0;
        @(negedge clk);
        chk("R2 idle acc_a", acc_a, exp_a);
        chk("R2 idle acc_b", acc_b, exp_b);

        // R5: unsigned fractional product 0xFFFF*0xFFFF doubled.
        run_op(4'd2, 1'b0, 16'hFFFF, 16'hFFFF, 7'b1000000, 1'b0);
        chk("R5 frac unsigned", acc_a, 40'h01FFFC0002);

        // R6: clear B, then add A into B sixty-four times.
        run_op(4'd1, 1'b1, 16'h1111, 16'h2222, 7'b0, 1'b1);
        chk("R6 clear B", acc_b, 40'h0);
        for (int k = 0; k < 64; k++)
            run_op(4'd11, 1'b1, 16'h0, 16'h0, 7'b0, 1'b1);
        chk("R6 add acc", acc_b, 40'h7FFF000080);

        // R7: one more add without saturation wraps past 2^39.
        run_op(4'd11, 1'b1, 16'h0, 16'h0, 7'b0, 1'b1);
        chk("R7 wrap", acc_b, 40'h81FEFC0082);
        run_op(4'd12, 1'b1, 16'h0, 16'h0, 7'b0, 1'b1);
        chk("R6 sub acc", acc_b, 40'h7FFF000080);

        // R9: the same add with full-width saturation clamps.
        run_op(4'd11, 1'b1, 16'h0, 16'h0, 7'b0000101, 1'b1);
        chk("R9 clamp max", acc_b, 40'h7FFFFFFFFF);

        // R8: A minus B with 32-bit saturation clamps negative.
        run_op(4'd12, 1'b0, 16'h0, 16'h0, 7'b0001000, 1'b0);
        chk("R8 clamp min", acc_a, 40'hFF80000000);
        chk("R10 word min", {24'h0, store_word}, 40'h8000);

        // R6: negate B under full-width saturation.
        run_op(4'd13, 1'b1, 16'h0, 16'h0, 7'b0000101, 1'b1);
        chk("R6 negate", acc_b, 40'h8000000001);
        run_op(4'd1, 1'b0, 16'h0, 16'h0, 7'b0, 1'b0);
        chk("R6 clear A", acc_a, 40'h0);
        chk("R2 clear A keeps B", acc_b, 40'h8000000001);

        // R1: reset in mid-run clears both accumulators.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        store_sel = 1'b1;
        chk("R1 mid reset acc_b", acc_b, 40'h0);
        chk("R1 mid reset word", {24'h0, store_word}, 40'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule